// File: doc/BRIEF.md
# Parallel Bit Extract/Deposit Unit

This block compresses or expands an arbitrary set of bits chosen by a selector mask. It does not move a fixed contiguous field. It works on one scalar word of `WIDTH` bits and takes two operands: a source word and a selector bitmap. A mode input picks one of two operations:

- **Gather (pack):** the source bits that sit under set selector bits are packed toward bit 0 of the result.
- **Scatter (unpack):** the lowest source bits are spread out to the positions where the selector is set.

The unit is iterative, which keeps the area to a few registers and one bit-wide mux path. It accepts a one-cycle start pulse while idle. It then steps through one selector position per clock, keeping a running index into the packed side. After `WIDTH` steps it drops busy, raises done for one cycle and presents the result. The result stays valid until the next operation completes.

Top module: `bitpack_unit`

## Requirements
- R1: While reset (`rst_n` low) is held and right after it is released, `busy` and `done` are 0 and `result` is all zeros.
- R2: A `start` sampled high at a clock edge while `busy` is 0 captures `src`, `sel` and `mode`, and `busy` reads 1 after that edge.
- R3: If start is accepted at edge k, `busy` falls and `done` is 1 after edge k+WIDTH. `done` is 1 for exactly that one cycle.
- R4: Gather (`mode`=0): the n-th set selector bit, counted upward from bit 0, gives the source bit at its position to result bit n.
- R5: Gather: every result bit at or above index popcount(sel) is 0.
- R6: Scatter (`mode`=1): the n-th set selector bit, counted upward from bit 0, receives source bit n at its own position in the result.
- R7: Scatter: every result bit whose selector bit is 0 is 0.
- R8: An all-zero selector gives a zero result in both modes.
- R9: An all-ones selector gives the source unchanged in both modes.
- R10: A `start` pulse while `busy` is 1 has no effect. The running operation keeps its operands and its completion cycle.
- R11: `result` changes only on the edge that raises `done`. Between completions it holds its value.
- R12: A `start` given in the cycle where `done` is 1 is accepted, because `busy` is already 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| mode | input | 1 | 0 = gather (pack), 1 = scatter (unpack) |
| src | input | WIDTH | Source word |
| sel | input | WIDTH | Selector bitmap |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | WIDTH | Last completed result, held |

## Verification
Two events can fall in the same cycle: completion of one operation (`done` high, `result` loaded) and acceptance of the next `start`. The bench provokes this by raising `start` with new operands in the very cycle it sees `done`. It then checks three things: the first result is still correct, `busy` rises on the next edge, and the second result arrives exactly `WIDTH` edges later. A similar overlap happens when `start` is pulsed during a running operation. In that case the bench checks that both the completion cycle and the result are those of the original operands.

// File: rtl/bitpack_unit.sv
module bitpack_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [WIDTH-1:0] src,
  input  logic [WIDTH-1:0] sel,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [IW-1:0] LAST = IW'(WIDTH - 1);

  logic [WIDTH-1:0] src_q, sel_q, acc, acc_nx;
  logic             mode_q;
  logic [IW-1:0]    step, ptr;

  wire           take   = sel_q[step];
  wire [IW-1:0]  wr_idx = mode_q ? step : ptr;
  wire           in_bit = mode_q ? src_q[ptr] : src_q[step];
  wire           accept = start && !busy;

  always_comb begin
    acc_nx = acc;
    if (take) acc_nx[wr_idx] = in_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      sel_q  <= '0;
      mode_q <= 1'b0;
      acc    <= '0;
      step   <= '0;
      ptr    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        src_q  <= src;
        sel_q  <= sel;
        mode_q <= mode;
        acc    <= '0;
        step   <= '0;
        ptr    <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        acc  <= acc_nx;
        step <= step + 1'b1;
        if (take) ptr <= ptr + 1'b1;
        if (step == LAST) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= acc_nx;
        end
      end
    end
  end
endmodule

// File: rtl/bitpack_unit_chk.sv
module bitpack_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             mode,
  input logic [WIDTH-1:0] src,
  input logic [WIDTH-1:0] sel,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result
);
  logic [31:0]      run;
  logic [WIDTH-1:0] sel_l;
  logic             mode_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= '0;
      sel_l  <= '0;
      mode_l <= 1'b0;
    end else if (start && !busy) begin
      run    <= '0;
      sel_l  <= sel;
      mode_l <= mode;
    end else if (busy) begin
      run <= run + 1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !busy && !done);
  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && run == WIDTH);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_pack_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done && !mode_l |-> (result >> $countones(sel_l)) == '0);
  a_r7_unpack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_l |-> (result & ~sel_l) == '0);
  a_r8_zero_sel: assert property (@(posedge clk) disable iff (!rst_n)
    done && sel_l == '0 |-> result == '0);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind bitpack_unit bitpack_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_bitpack_unit.sv
module sim_bitpack_unit;
  localparam int W = 32;
  logic clk = 0, rst_n = 0, start = 0, mode = 0;
  logic [W-1:0] src = '0, sel = '0;
  logic busy, done;
  logic [W-1:0] result;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  bitpack_unit #(.WIDTH(W)) u0 (.*);

  function automatic logic [W-1:0] ref_pack(logic [W-1:0] s, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int n = 0;
    for (int i = 0; i < W; i++) if (m[i]) begin r[n] = s[i]; n++; end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_unpack(logic [W-1:0] s, logic [W-1:0] m);
    logic [W-1:0] r = '0;
    int n = 0;
    for (int i = 0; i < W; i++) if (m[i]) begin r[i] = s[n]; n++; end
    return r;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic launch(logic m, logic [W-1:0] s, logic [W-1:0] k);
    mode = m; src = s; sel = k; start = 1;
  endtask

  // called away from an edge with start already raised; returns after done seen
  task automatic finish_op(logic m, logic [W-1:0] s, logic [W-1:0] k,
                           int poke_at, logic [W-1:0] junk);
    int cyc = 1;
    logic [W-1:0] exp = m ? ref_unpack(s, k) : ref_pack(s, k);
    @(posedge clk); #1;
    start = 0;
    chk("R2 busy after accept", W'(busy), W'(1));
    while (!done && cyc < W + 8) begin
      if (cyc == poke_at) begin
        mode = ~m; src = junk; sel = ~junk; start = 1;   // R10 poke while busy
      end
      @(posedge clk); #1;
      start = 0;
      cyc++;
    end
    chk("R3 latency", W'(cyc), W'(W + 1));
    chk("R3 busy low at done", W'(busy), W'(0));
    chk(m ? "R6 unpack result" : "R4 pack result", result, exp);
    if (m) chk("R7 unselected zero", result & ~k, '0);
    else   chk("R5 high bits zero", result >> $countones(k), '0);
  endtask

  task automatic op(logic m, logic [W-1:0] s, logic [W-1:0] k);
    @(negedge clk);
    launch(m, s, k);
    finish_op(m, s, k, -1, '0);
    @(posedge clk); #1;
    chk("R3 done single cycle", W'(done), W'(0));
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] held, s1, k1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy in reset", W'(busy), W'(0));
    chk("R1 done in reset", W'(done), W'(0));
    chk("R1 result in reset", result, '0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 idle after release", W'({busy, done}), W'(0));

    // R8 zero selector, R9 all-ones selector
    op(0, 32'hDEAD_BEEF, '0);  chk("R8 pack zero sel", result, '0);
    op(1, 32'hDEAD_BEEF, '0);  chk("R8 unpack zero sel", result, '0);
    op(0, 32'hA5C3_0F96, '1);  chk("R9 pack all-ones", result, 32'hA5C3_0F96);
    op(1, 32'hA5C3_0F96, '1);  chk("R9 unpack all-ones", result, 32'hA5C3_0F96);
    op(0, 32'h8000_0000, 32'h8000_0000); chk("R4 top bit to bit0", result, 32'h1);
    op(1, 32'h0000_0001, 32'h8000_0000); chk("R6 bit0 to top", result, 32'h8000_0000);
    op(0, 32'hFFFF_FFFF, 32'hAAAA_AAAA); chk("R4 alternating", result, 32'h0000_FFFF);
    op(1, 32'h0000_FFFF, 32'h5555_5555); chk("R6 alternating", result, 32'h5555_5555);

    // R11 hold between completions
    held = result;
    repeat (5) @(posedge clk);
    #1 chk("R11 result held", result, held);

    // R10 start while busy ignored
    @(negedge clk);
    launch(0, 32'h1234_5678, 32'h0F0F_F0F0);
    finish_op(0, 32'h1234_5678, 32'h0F0F_F0F0, 7, 32'hCAFE_F00D);
    chk("R10 busy-start ignored", result, ref_pack(32'h1234_5678, 32'h0F0F_F0F0));

    // R12 start in the done cycle
    s1 = 32'h0BAD_CAFE; k1 = 32'hFF00_0FF0;
    launch(1, s1, k1);
    finish_op(1, s1, k1, -1, '0);
    chk("R12 back-to-back accepted", result, ref_unpack(s1, k1));

    void'($urandom(32'd1234));
    for (int i = 0; i < 80; i++) begin
      logic [W-1:0] rs, rk;
      rs = $urandom; rk = $urandom;
      if (i % 4 == 1) rk = rk & $urandom;
      if (i % 4 == 2) rk = rk | $urandom;
      op(1'(i % 2), rs, rk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule